// File: doc/BRIEF.md
# Output Compare Channel with Power-Mode Gating

This block is one output compare channel. It picks one of two external timer counts as its time base and compares it against a compare value or a PWM duty value. It drives a single output pin and keeps sticky interrupt flags with enables. The two timers are not part of the block. They appear only as count, enable, stop-in-idle and period-event inputs.

A CPU power manager supplies the sleep and idle inputs. In sleep the channel freezes: the pin keeps its level and no flag is set by hardware. In idle the channel keeps running only if its own stop-in-idle bit is clear and the selected timer is enabled with its stop-in-idle bit clear. In every other case idle freezes the channel the same way sleep does. The non-PWM modes report a compare match through the channel flag. PWM mode reports its period event through the flag of the selected timer.

Top module: `ocpm_top`

## Requirements
- R1: After reset the pin, all three flags and all three interrupt requests are 0.
- R2: `tbase_sel_i` = 0 selects timer A (count and period event); 1 selects timer B.
- R3: Mode 1 (set-high). On the first running cycle in the mode, the pin is driven 0. One cycle after a running cycle in which the selected count equals `cmp_i`, the pin is 1, and it stays 1.
- R4: Mode 2 (set-low). On the first running cycle in the mode, the pin is driven 1. One cycle after a match, the pin is 0, and it stays 0.
- R5: Mode 3 (toggle). The pin inverts one cycle after each running cycle with a match.
- R6: Mode 0 and the unused codes 5 to 7 drive the pin to 0 while running and never set any flag.
- R7: While `sleep_i` = 1, the pin, the active duty value and the mode tracking all hold. No flag is set by hardware. After wake-up, operation continues from the held state.
- R8: While `idle_i` = 1 and `sleep_i` = 0, the channel runs only if `ch_stop_idle_i` = 0, the selected timer's run input is 1 and the selected timer's stop-in-idle input is 0. Otherwise it is frozen as in R7.
- R9: In modes 1 to 3, a match on a running cycle sets the channel flag one cycle later. The flag stays set until a clear input is sampled. If a set and a clear occur in the same cycle, the flag is set.
- R10: Each interrupt request is its flag ANDed with its enable input.
- R11: Mode 4 (PWM). The pin is 1 one cycle after a running period event of the selected timer. Otherwise it is 0 one cycle after the count equals the active duty. The channel flag is never set.
- R12: In PWM, the active duty takes `duty_i` only on entry to the mode and on a running period event. Changes to `duty_i` at other times have no effect until then.
- R13: In PWM, a running period event sets the selected timer's flag one cycle later. That flag is sticky, and a set beats a clear. The unselected timer's flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | CPU sleep state |
| idle_i | input | 1 | CPU idle state |
| ch_stop_idle_i | input | 1 | Channel stops in idle |
| tbase_sel_i | input | 1 | Time-base select, 0 = A, 1 = B |
| mode_i | input | 3 | Channel mode code |
| cmp_i | input | CW | Compare value |
| duty_i | input | CW | PWM duty value, buffered |
| tmra_cnt_i | input | CW | Timer A count |
| tmrb_cnt_i | input | CW | Timer B count |
| tmra_run_i | input | 1 | Timer A enabled |
| tmrb_run_i | input | 1 | Timer B enabled |
| tmra_stop_idle_i | input | 1 | Timer A stops in idle |
| tmrb_stop_idle_i | input | 1 | Timer B stops in idle |
| tmra_prd_i | input | 1 | Timer A period event |
| tmrb_prd_i | input | 1 | Timer B period event |
| ch_ie_i | input | 1 | Channel interrupt enable |
| tmra_ie_i | input | 1 | Timer A interrupt enable |
| tmrb_ie_i | input | 1 | Timer B interrupt enable |
| ch_flag_clr_i | input | 1 | Software clear of channel flag |
| tmra_flag_clr_i | input | 1 | Software clear of timer A flag |
| tmrb_flag_clr_i | input | 1 | Software clear of timer B flag |
| oc_pin_o | output | 1 | Output pin |
| ch_flag_o | output | 1 | Channel interrupt flag |
| tmra_flag_o | output | 1 | Timer A interrupt flag |
| tmrb_flag_o | output | 1 | Timer B interrupt flag |
| ch_irq_o | output | 1 | Channel interrupt request |
| tmra_irq_o | output | 1 | Timer A interrupt request |
| tmrb_irq_o | output | 1 | Timer B interrupt request |

## Verification
The assertions assume that the power and mode inputs are synchronous to the clock. They also assume that the off-mode property is only evaluated while neither sleep nor idle is active, so that the channel is known to be running. The assertions place no limit on how timer counts relate to the compare or duty values. The stimulus comes from two free-running timer counters in the bench, each with its own period. Every power, select and mode change is applied on the falling edge. Random phases hold each setting for 16 cycles and pick compare and duty values inside the timer range, so matches actually happen.

// File: rtl/ocpm_pkg.sv
package ocpm_pkg;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] OC_OFF    = 3'd0;
  localparam logic [MODE_W-1:0] OC_SET_HI = 3'd1;
  localparam logic [MODE_W-1:0] OC_SET_LO = 3'd2;
  localparam logic [MODE_W-1:0] OC_TOGGLE = 3'd3;
  localparam logic [MODE_W-1:0] OC_PWM    = 3'd4;
  localparam int NTMR = 2;
endpackage

// File: rtl/ocpm_gate.sv
module ocpm_gate #(
  parameter int CW = 16
) (
  input  logic                      sleep_i,
  input  logic                      idle_i,
  input  logic                      ch_sidl_i,
  input  logic                      sel_i,
  input  logic [ocpm_pkg::NTMR-1:0] tmr_run_i,
  input  logic [ocpm_pkg::NTMR-1:0] tmr_sidl_i,
  input  logic [ocpm_pkg::NTMR-1:0] tmr_prd_i,
  input  logic [CW-1:0]             cnt_a_i,
  input  logic [CW-1:0]             cnt_b_i,
  output logic                      run_o,
  output logic [CW-1:0]             cnt_o,
  output logic                      prd_o
);
  logic idle_ok;

  always_comb begin
    cnt_o   = sel_i ? cnt_b_i : cnt_a_i;
    prd_o   = tmr_prd_i[sel_i];
    idle_ok = !ch_sidl_i && tmr_run_i[sel_i] && !tmr_sidl_i[sel_i];
    run_o   = !sleep_i && (!idle_i || idle_ok);
  end
endmodule

// File: rtl/ocpm_wave.sv
module ocpm_wave #(
  parameter int CW = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        run_i,
  input  logic [ocpm_pkg::MODE_W-1:0] mode_i,
  input  logic [CW-1:0]               cnt_i,
  input  logic [CW-1:0]               cmp_i,
  input  logic [CW-1:0]               duty_i,
  input  logic                        prd_i,
  output logic                        pin_o,
  output logic                        ch_set_o,
  output logic                        prd_set_o
);
  import ocpm_pkg::*;

  logic                pin_q, pin_d;
  logic [CW-1:0]       duty_q, duty_d;
  logic [MODE_W-1:0]   mode_q, mode_d;
  logic                hit_cmp, hit_duty;

  always_comb begin
    pin_d     = pin_q;
    duty_d    = duty_q;
    mode_d    = mode_q;
    ch_set_o  = 1'b0;
    prd_set_o = 1'b0;
    hit_cmp   = (cnt_i == cmp_i);
    hit_duty  = (cnt_i == duty_q);
    if (run_i) begin
      if (mode_i != mode_q) begin
        mode_d = mode_i;
        pin_d  = (mode_i == OC_SET_LO);
        duty_d = duty_i;
      end else begin
        case (mode_i)
          OC_SET_HI: if (hit_cmp) begin pin_d = 1'b1;   ch_set_o = 1'b1; end
          OC_SET_LO: if (hit_cmp) begin pin_d = 1'b0;   ch_set_o = 1'b1; end
          OC_TOGGLE: if (hit_cmp) begin pin_d = !pin_q; ch_set_o = 1'b1; end
          OC_PWM: begin
            if (prd_i) begin
              pin_d     = 1'b1;
              duty_d    = duty_i;
              prd_set_o = 1'b1;
            end else if (hit_duty) begin
              pin_d = 1'b0;
            end
          end
          default: pin_d = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      duty_q <= '0;
      mode_q <= OC_OFF;
    end else if (run_i) begin
      pin_q  <= pin_d;
      duty_q <= duty_d;
      mode_q <= mode_d;
    end
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/ocpm_flag.sv
module ocpm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, flag_d, upd;

  always_comb begin
    upd    = set_i || clr_i;
    flag_d = set_i ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (upd) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && ie_i;
endmodule

// File: rtl/ocpm_top.sv
module ocpm_top #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_i,
  input  logic          idle_i,
  input  logic          ch_stop_idle_i,
  input  logic          tbase_sel_i,
  input  logic [2:0]    mode_i,
  input  logic [CW-1:0] cmp_i,
  input  logic [CW-1:0] duty_i,
  input  logic [CW-1:0] tmra_cnt_i,
  input  logic [CW-1:0] tmrb_cnt_i,
  input  logic          tmra_run_i,
  input  logic          tmrb_run_i,
  input  logic          tmra_stop_idle_i,
  input  logic          tmrb_stop_idle_i,
  input  logic          tmra_prd_i,
  input  logic          tmrb_prd_i,
  input  logic          ch_ie_i,
  input  logic          tmra_ie_i,
  input  logic          tmrb_ie_i,
  input  logic          ch_flag_clr_i,
  input  logic          tmra_flag_clr_i,
  input  logic          tmrb_flag_clr_i,
  output logic          oc_pin_o,
  output logic          ch_flag_o,
  output logic          tmra_flag_o,
  output logic          tmrb_flag_o,
  output logic          ch_irq_o,
  output logic          tmra_irq_o,
  output logic          tmrb_irq_o
);
  import ocpm_pkg::*;
  localparam int NFLAG = NTMR + 1;

  logic          run;
  logic [CW-1:0] cnt_sel;
  logic          prd_sel;
  logic          ch_set, prd_set;
  logic [NFLAG-1:0] f_set, f_clr, f_ie, f_flag, f_irq;

  ocpm_gate #(.CW(CW)) u_gate (
    .sleep_i    (sleep_i),
    .idle_i     (idle_i),
    .ch_sidl_i  (ch_stop_idle_i),
    .sel_i      (tbase_sel_i),
    .tmr_run_i  ({tmrb_run_i, tmra_run_i}),
    .tmr_sidl_i ({tmrb_stop_idle_i, tmra_stop_idle_i}),
    .tmr_prd_i  ({tmrb_prd_i, tmra_prd_i}),
    .cnt_a_i    (tmra_cnt_i),
    .cnt_b_i    (tmrb_cnt_i),
    .run_o      (run),
    .cnt_o      (cnt_sel),
    .prd_o      (prd_sel)
  );

  ocpm_wave #(.CW(CW)) u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .mode_i    (mode_i),
    .cnt_i     (cnt_sel),
    .cmp_i     (cmp_i),
    .duty_i    (duty_i),
    .prd_i     (prd_sel),
    .pin_o     (oc_pin_o),
    .ch_set_o  (ch_set),
    .prd_set_o (prd_set)
  );

  // index 0: channel, 1: timer A, 2: timer B
  always_comb begin
    f_set = {prd_set && tbase_sel_i, prd_set && !tbase_sel_i, ch_set};
    f_clr = {tmrb_flag_clr_i, tmra_flag_clr_i, ch_flag_clr_i};
    f_ie  = {tmrb_ie_i, tmra_ie_i, ch_ie_i};
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    ocpm_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (f_set[g]),
      .clr_i  (f_clr[g]),
      .ie_i   (f_ie[g]),
      .flag_o (f_flag[g]),
      .irq_o  (f_irq[g])
    );
  end

  assign ch_flag_o   = f_flag[0];
  assign tmra_flag_o = f_flag[1];
  assign tmrb_flag_o = f_flag[2];
  assign ch_irq_o    = f_irq[0];
  assign tmra_irq_o  = f_irq[1];
  assign tmrb_irq_o  = f_irq[2];
endmodule

// File: rtl/ocpm_checker.sv
module ocpm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_i,
  input logic       idle_i,
  input logic       ch_stop_idle_i,
  input logic [2:0] mode_i,
  input logic       ch_flag_clr_i,
  input logic       tmra_flag_clr_i,
  input logic       oc_pin_o,
  input logic       ch_flag_o,
  input logic       tmra_flag_o
);
  assert_sleep_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> $stable(oc_pin_o));

  assert_idle_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && ch_stop_idle_i) |=> $stable(oc_pin_o));

  assert_off_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && !idle_i && mode_i == 3'd0) |=> !oc_pin_o);

  assert_ch_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_flag_o && !ch_flag_clr_i) |=> ch_flag_o);

  assert_pwm_no_chflag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd4 && !ch_flag_o) |=> !ch_flag_o);

  assert_tmr_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (tmra_flag_o && !tmra_flag_clr_i) |=> tmra_flag_o);
endmodule

bind ocpm_top ocpm_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .sleep_i         (sleep_i),
  .idle_i          (idle_i),
  .ch_stop_idle_i  (ch_stop_idle_i),
  .mode_i          (mode_i),
  .ch_flag_clr_i   (ch_flag_clr_i),
  .tmra_flag_clr_i (tmra_flag_clr_i),
  .oc_pin_o        (oc_pin_o),
  .ch_flag_o       (ch_flag_o),
  .tmra_flag_o     (tmra_flag_o)
);

// File: tb/ocpm_top_test.sv
module ocpm_top_test;
  localparam int CW = 16;
  localparam int PA = 9;
  localparam int PB = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic sleep_i, idle_i, ch_stop_idle_i, tbase_sel_i;
  logic [2:0] mode_i;
  logic [CW-1:0] cmp_i, duty_i, tmra_cnt_i, tmrb_cnt_i;
  logic tmra_run_i, tmrb_run_i, tmra_stop_idle_i, tmrb_stop_idle_i;
  logic tmra_prd_i, tmrb_prd_i, ch_ie_i, tmra_ie_i, tmrb_ie_i;
  logic ch_flag_clr_i, tmra_flag_clr_i, tmrb_flag_clr_i;
  logic oc_pin_o, ch_flag_o, tmra_flag_o, tmrb_flag_o, ch_irq_o, tmra_irq_o, tmrb_irq_o;

  ocpm_top #(.CW(CW)) uut (.*);

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  logic checking = 1'b0;

  // expected state
  logic e_pin, e_ch, e_ta, e_tb;
  logic [2:0] e_mq;
  logic [CW-1:0] e_duty;
  logic m_run, m_cs, m_as, m_bs, m_prd;
  logic [CW-1:0] m_cnt;

  function automatic logic may_run(input logic slp, idl, csidl, sel,
                                   ena, enb, sa, sb);
    logic ok;
    ok = !csidl && (sel ? (enb && !sb) : (ena && !sa));
    return !slp && (!idl || ok);
  endfunction

  function automatic logic sticky(input logic cur, set, clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_pin = 0; e_ch = 0; e_ta = 0; e_tb = 0; e_mq = 0; e_duty = 0;
    end else begin
      m_cnt = tbase_sel_i ? tmrb_cnt_i : tmra_cnt_i;
      m_prd = tbase_sel_i ? tmrb_prd_i : tmra_prd_i;
      m_run = may_run(sleep_i, idle_i, ch_stop_idle_i, tbase_sel_i,
                      tmra_run_i, tmrb_run_i, tmra_stop_idle_i, tmrb_stop_idle_i);
      m_cs = 0; m_as = 0; m_bs = 0;
      if (m_run) begin
        if (mode_i != e_mq) begin
          e_mq = mode_i; e_pin = (mode_i == 3'd2); e_duty = duty_i;
        end else if (mode_i >= 3'd1 && mode_i <= 3'd3) begin
          if (m_cnt == cmp_i) begin
            m_cs = 1;
            e_pin = (mode_i == 3'd1) ? 1'b1 : (mode_i == 3'd2) ? 1'b0 : !e_pin;
          end
        end else if (mode_i == 3'd4) begin
          if (m_prd) begin
            e_pin = 1; e_duty = duty_i;
            if (tbase_sel_i) m_bs = 1; else m_as = 1;
          end else if (m_cnt == e_duty) e_pin = 0;
        end else e_pin = 0;
      end
      e_ch = sticky(e_ch, m_cs, ch_flag_clr_i);
      e_ta = sticky(e_ta, m_as, tmra_flag_clr_i);
      e_tb = sticky(e_tb, m_bs, tmrb_flag_clr_i);
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // output checks and timer stimulus, both on the falling edge
  always @(negedge clk) begin
    if (rst_n && checking) begin
      chk(cur_req, "pin", oc_pin_o, e_pin);
      chk(cur_req, "ch_flag", ch_flag_o, e_ch);
      chk(cur_req, "tmra_flag", tmra_flag_o, e_ta);
      chk(cur_req, "tmrb_flag", tmrb_flag_o, e_tb);
      chk(cur_req, "ch_irq (R10)", ch_irq_o, e_ch && ch_ie_i);
      chk(cur_req, "tmra_irq (R10)", tmra_irq_o, e_ta && tmra_ie_i);
      chk(cur_req, "tmrb_irq (R10)", tmrb_irq_o, e_tb && tmrb_ie_i);
    end
    if (rst_n) begin
      tmra_cnt_i = (tmra_cnt_i == PA) ? '0 : tmra_cnt_i + 1'b1;
      tmrb_cnt_i = (tmrb_cnt_i == PB) ? '0 : tmrb_cnt_i + 1'b1;
      tmra_prd_i = (tmra_cnt_i == PA);
      tmrb_prd_i = (tmrb_cnt_i == PB);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr(input int n);
    for (int i = 0; i < n; i++) begin
      ch_flag_clr_i = (i % 7 == 3); tmra_flag_clr_i = (i % 5 == 2); tmrb_flag_clr_i = (i % 6 == 1);
      step(1);
    end
    ch_flag_clr_i = 0; tmra_flag_clr_i = 0; tmrb_flag_clr_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C01));
    sleep_i = 0; idle_i = 0; ch_stop_idle_i = 0; tbase_sel_i = 0; mode_i = 0;
    cmp_i = 0; duty_i = 0; tmra_cnt_i = 0; tmrb_cnt_i = 0;
    tmra_run_i = 1; tmrb_run_i = 1; tmra_stop_idle_i = 0; tmrb_stop_idle_i = 0;
    tmra_prd_i = 0; tmrb_prd_i = 0; ch_ie_i = 0; tmra_ie_i = 0; tmrb_ie_i = 0;
    ch_flag_clr_i = 0; tmra_flag_clr_i = 0; tmrb_flag_clr_i = 0;
    step(3);
    rst_n = 1;
    @(negedge clk);
    // R1: reset values directly
    chk("R1", "pin after reset", oc_pin_o, 1'b0);
    chk("R1", "ch_flag after reset", ch_flag_o, 1'b0);
    chk("R1", "tmra_flag after reset", tmra_flag_o, 1'b0);
    chk("R1", "tmrb_irq after reset", tmrb_irq_o, 1'b0);
    checking = 1;
    step(4);

    cur_req = "R3"; mode_i = 3'd1; cmp_i = 5; ch_ie_i = 1; step(30);
    cur_req = "R9"; pulse_clr(30);
    cur_req = "R2"; tbase_sel_i = 1; mode_i = 3'd3; cmp_i = 11; step(60);
    cur_req = "R4"; tbase_sel_i = 0; mode_i = 3'd2; cmp_i = 4; step(30);
    cur_req = "R5"; mode_i = 3'd3; cmp_i = 7; step(50);
    cur_req = "R6"; mode_i = 3'd0; step(20); mode_i = 3'd6; step(20);
    cur_req = "R7"; mode_i = 3'd3; cmp_i = 2; step(13);
    sleep_i = 1; step(25); sleep_i = 0; step(25);
    cur_req = "R8"; idle_i = 1; step(25);
    ch_stop_idle_i = 1; step(25); ch_stop_idle_i = 0;
    tmra_run_i = 0; step(25); tmra_run_i = 1;
    tmra_stop_idle_i = 1; step(25); tmra_stop_idle_i = 0;
    tmrb_stop_idle_i = 1; step(25); tmrb_stop_idle_i = 0; idle_i = 0;
    cur_req = "R9"; ch_flag_clr_i = 1; step(30); ch_flag_clr_i = 0; step(10); pulse_clr(40);
    cur_req = "R10"; ch_ie_i = 0; step(10); ch_ie_i = 1; step(10);
    cur_req = "R11"; mode_i = 3'd4; duty_i = 3; step(40);
    cur_req = "R12";
    for (int i = 0; i < 12; i++) begin duty_i = CW'(i % 8); step(5); end
    cur_req = "R13"; tmra_ie_i = 1; tmrb_ie_i = 1; pulse_clr(40);
    tbase_sel_i = 1; duty_i = 6; step(30); pulse_clr(40);
    tmrb_flag_clr_i = 1; step(30); tmrb_flag_clr_i = 0;

    cur_req = "R8";
    for (int k = 0; k < 200; k++) begin
      mode_i = 3'($urandom_range(0, 7));
      tbase_sel_i = 1'($urandom_range(0, 1));
      cmp_i = CW'($urandom_range(0, PB));
      duty_i = CW'($urandom_range(0, PB));
      sleep_i = ($urandom_range(0, 5) == 0);
      idle_i = ($urandom_range(0, 3) == 0);
      ch_stop_idle_i = ($urandom_range(0, 3) == 0);
      tmra_run_i = ($urandom_range(0, 4) != 0);
      tmrb_run_i = ($urandom_range(0, 4) != 0);
      tmra_stop_idle_i = ($urandom_range(0, 3) == 0);
      tmrb_stop_idle_i = ($urandom_range(0, 3) == 0);
      ch_ie_i = 1'($urandom_range(0, 1));
      tmra_ie_i = 1'($urandom_range(0, 1));
      tmrb_ie_i = 1'($urandom_range(0, 1));
      for (int j = 0; j < 16; j++) begin
        ch_flag_clr_i = ($urandom_range(0, 7) == 0);
        tmra_flag_clr_i = ($urandom_range(0, 7) == 0);
        tmrb_flag_clr_i = ($urandom_range(0, 7) == 0);
        step(1);
      end
    end
    checking = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule